// File: doc/BRIEF.md
# Non-Zero Bin Compactor

This block takes a bank of bin counts and produces a packed list holding only the bins whose count is non-zero. Each list entry pairs the original bin number with that bin's count, and the entries keep ascending bin order. The block also reports how many entries are valid. It is meant to sit after a histogram accumulator, so that later stages can walk a short list instead of the whole bank.

Internally every bin gets a one-bit occupancy flag. An inclusive running sum is formed over the flags by a doubling scan that finishes one stage per clock. Each occupied bin is then written straight to its slot, which is one less than its running sum, in a single scatter cycle. A request is a one-cycle pulse on `valid_i` together with the count bank. The result registers then update once and a one-cycle `done_o` is raised. While a request is in progress, further pulses are ignored.

Top module: `hc_compact`

## Requirements
- R1: The count bank has 256 bins. Bin i occupies bits [i*8 +: 8] of `counts_i`. Output slot k occupies bits [k*8 +: 8] of `idx_o` and of `cnt_o`.
- R2: Let b(k) be the k-th non-zero bin in ascending bin order, counting from 0. Slot k then holds bin number b(k) in `idx_o` and that bin's count in `cnt_o`.
- R3: `num_o` equals the number of bins with a count greater than zero, in the range 0 to 256.
- R4: Every slot k with k >= `num_o` reads zero in both `idx_o` and `cnt_o`.
- R5: `done_o` is high for exactly one cycle. It rises at the 10th rising clock edge after the edge that accepts `valid_i`, counting the accepting edge as edge 0. This covers one capture cycle, 8 scan stages and one scatter cycle, and the results are valid in that same cycle.
- R6: A `valid_i` pulse that arrives before `done_o` of the current request is ignored. The result is that of the accepted bank, and no second `done_o` follows.
- R7: A bank of all zeros yields `num_o` = 0, all slots zero, and still raises `done_o`.
- R8: After reset, `done_o` is 0, `num_o` is 0 and all slots are zero.
- R9: `num_o`, `idx_o` and `cnt_o` hold their values from one `done_o` until the next completion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | One-cycle request pulse |
| counts_i | input | 2048 | Bin counts, 8 bits per bin |
| idx_o | output | 2048 | Compacted bin numbers, 8 bits per slot |
| cnt_o | output | 2048 | Compacted counts, 8 bits per slot |
| num_o | output | 9 | Number of valid slots |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The hardest case to reach is a fully occupied bank. There the final running sum needs its ninth bit, and the last bin lands in the top slot, which no sparse pattern touches. A second hard case is a request pulse arriving mid-scan. The bench drives the all-ones and all-maximum banks, single bins at both ends, and sweeps of random occupancy from empty to full. It also fires a second, different bank two cycles into a run and checks that the first bank's result comes out alone.

// File: rtl/hc_pkg.sv
package hc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SCAN = 2'd1,
    ST_SCAT = 2'd2
  } hc_state_e;
endpackage

// File: rtl/hc_scan.sv
module hc_scan #(
  parameter int NUM_BINS = 256,
  parameter int SUM_W    = 9,
  parameter int LOG_N    = 8,
  parameter int STEP_W   = 3
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      load_i,
  input  logic [NUM_BINS-1:0]       flags_i,
  input  logic                      adv_i,
  input  logic [STEP_W-1:0]         step_i,
  output logic [NUM_BINS*SUM_W-1:0] sums_o
);
  logic [SUM_W-1:0] sum_q   [NUM_BINS];
  logic [SUM_W-1:0] partner [NUM_BINS];

  // doubling distance selected by the current stage
  always_comb begin
    for (int i = 0; i < NUM_BINS; i++) begin
      partner[i] = '0;
      for (int k = 0; k < LOG_N; k++) begin
        int src;
        src = i - (1 << k);
        if (step_i == STEP_W'(k) && src >= 0) partner[i] = sum_q[src];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NUM_BINS; i++) sum_q[i] <= '0;
    end else if (load_i) begin
      for (int i = 0; i < NUM_BINS; i++) sum_q[i] <= SUM_W'(flags_i[i]);
    end else if (adv_i) begin
      for (int i = 0; i < NUM_BINS; i++) sum_q[i] <= sum_q[i] + partner[i];
    end
  end

  always_comb begin
    for (int i = 0; i < NUM_BINS; i++) sums_o[i*SUM_W +: SUM_W] = sum_q[i];
  end

  for (genvar g = 0; g < NUM_BINS; g++) begin : g_bound
    // R3: a partial sum never exceeds the number of bins it can cover
    a_r3_sum_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
      int'(sum_q[g]) <= g + 1);
  end
endmodule

// File: rtl/hc_scatter.sv
module hc_scatter #(
  parameter int NUM_BINS = 256,
  parameter int CNT_W    = 8,
  parameter int IDX_W    = 8,
  parameter int SUM_W    = 9
) (
  input  logic [NUM_BINS-1:0]       flags_i,
  input  logic [NUM_BINS*CNT_W-1:0] counts_i,
  input  logic [NUM_BINS*SUM_W-1:0] sums_i,
  output logic [NUM_BINS*IDX_W-1:0] idx_o,
  output logic [NUM_BINS*CNT_W-1:0] cnt_o
);
  always_comb begin
    idx_o = '0;
    cnt_o = '0;
    for (int i = 0; i < NUM_BINS; i++) begin
      logic [SUM_W-1:0] slot;
      int s;
      slot = sums_i[i*SUM_W +: SUM_W] - SUM_W'(1);
      s    = int'(slot[IDX_W-1:0]);
      if (flags_i[i]) begin
        idx_o[s*IDX_W +: IDX_W] = IDX_W'(i);
        cnt_o[s*CNT_W +: CNT_W] = counts_i[i*CNT_W +: CNT_W];
      end
    end
  end
endmodule

// File: rtl/hc_compact.sv
module hc_compact #(
  parameter int NUM_BINS = 256,
  parameter int CNT_W    = 8
) (
  input  logic                                   clk_i,
  input  logic                                   rst_ni,
  input  logic                                   valid_i,
  input  logic [NUM_BINS*CNT_W-1:0]              counts_i,
  output logic [NUM_BINS*$clog2(NUM_BINS)-1:0]   idx_o,
  output logic [NUM_BINS*CNT_W-1:0]              cnt_o,
  output logic [$clog2(NUM_BINS):0]              num_o,
  output logic                                   done_o
);
  import hc_pkg::*;

  localparam int IDX_W  = $clog2(NUM_BINS);
  localparam int SUM_W  = IDX_W + 1;
  localparam int LOG_N  = IDX_W;
  localparam int STEP_W = (LOG_N > 1) ? $clog2(LOG_N) : 1;

  hc_state_e                 state_q;
  logic [STEP_W-1:0]         step_q;
  logic [NUM_BINS*CNT_W-1:0] cnt_q;
  logic [NUM_BINS-1:0]       flags_in, flags_q;
  logic [NUM_BINS*SUM_W-1:0] sums;
  logic [NUM_BINS*IDX_W-1:0] scat_idx;
  logic [NUM_BINS*CNT_W-1:0] scat_cnt;
  logic                      accept, adv;

  assign accept = valid_i && (state_q == ST_IDLE);
  assign adv    = (state_q == ST_SCAN);

  always_comb begin
    for (int i = 0; i < NUM_BINS; i++) begin
      flags_in[i] = |counts_i[i*CNT_W +: CNT_W];
      flags_q[i]  = |cnt_q[i*CNT_W +: CNT_W];
    end
  end

  hc_scan #(
    .NUM_BINS(NUM_BINS), .SUM_W(SUM_W), .LOG_N(LOG_N), .STEP_W(STEP_W)
  ) u_scan (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (accept),
    .flags_i(flags_in),
    .adv_i  (adv),
    .step_i (step_q),
    .sums_o (sums)
  );

  hc_scatter #(
    .NUM_BINS(NUM_BINS), .CNT_W(CNT_W), .IDX_W(IDX_W), .SUM_W(SUM_W)
  ) u_scatter (
    .flags_i (flags_q),
    .counts_i(cnt_q),
    .sums_i  (sums),
    .idx_o   (scat_idx),
    .cnt_o   (scat_cnt)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      step_q  <= '0;
      cnt_q   <= '0;
      idx_o   <= '0;
      cnt_o   <= '0;
      num_o   <= '0;
      done_o  <= 1'b0;
    end else begin
      done_o <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (valid_i) begin
          cnt_q   <= counts_i;
          step_q  <= '0;
          state_q <= ST_SCAN;
        end
        ST_SCAN: begin
          step_q <= step_q + STEP_W'(1);
          if (step_q == STEP_W'(LOG_N - 1)) state_q <= ST_SCAT;
        end
        ST_SCAT: begin
          idx_o   <= scat_idx;
          cnt_o   <= scat_cnt;
          num_o   <= sums[(NUM_BINS-1)*SUM_W +: SUM_W];
          done_o  <= 1'b1;
          state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // R5: scatter cycle is followed by a single done pulse
  a_r5_done_after_scatter: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_SCAT) |=> done_o);
  a_r5_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  // R6: captured bank is untouched by requests during a run
  a_r6_busy_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q != ST_IDLE && valid_i) |=> $stable(cnt_q));
  // R9: results only change on the scatter cycle
  a_r9_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q != ST_SCAT) |=> ($stable(num_o) && $stable(idx_o) && $stable(cnt_o)));

  for (genvar j = 0; j < NUM_BINS; j++) begin : g_tail
    // R4: slots past the valid count are zero
    a_r4_tail_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (done_o && (j >= int'(num_o))) |->
        (idx_o[j*IDX_W +: IDX_W] == '0 && cnt_o[j*CNT_W +: CNT_W] == '0));
  end
endmodule

// File: tb/sim_hc_compact.sv
`timescale 1ns/1ps
module sim_hc_compact;
  localparam int NB = 256;
  localparam int CW = 8;
  localparam int IW = 8;

  logic              clk = 1'b0;
  logic              rst_ni = 1'b0;
  logic              valid_i = 1'b0;
  logic [NB*CW-1:0]  counts_i = '0;
  logic [NB*IW-1:0]  idx_o;
  logic [NB*CW-1:0]  cnt_o;
  logic [IW:0]       num_o;
  logic              done_o;

  int checks = 0;
  int errors = 0;
  logic [CW-1:0] hist [NB];

  always #2 clk = ~clk;

  hc_compact #(.NUM_BINS(NB), .CNT_W(CW)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .valid_i(valid_i), .counts_i(counts_i),
    .idx_o(idx_o), .cnt_o(cnt_o), .num_o(num_o), .done_o(done_o)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic logic [NB*CW-1:0] pack_hist();
    logic [NB*CW-1:0] v;
    for (int i = 0; i < NB; i++) v[i*CW +: CW] = hist[i];
    return v;
  endfunction

  // compares outputs against the bank held in hist
  task automatic check_result(input string tag);
    int k, bad_ord, bad_tail, first_act, first_exp;
    k = 0; bad_ord = 0; bad_tail = 0; first_act = 0; first_exp = 0;
    for (int i = 0; i < NB; i++) begin
      if (hist[i] != 0) begin
        if (int'(idx_o[k*IW +: IW]) != i || cnt_o[k*CW +: CW] != hist[i]) begin
          if (bad_ord == 0) begin first_act = int'(idx_o[k*IW +: IW]); first_exp = i; end
          bad_ord++;
        end
        k++;
      end
    end
    for (int j = k; j < NB; j++)
      if (idx_o[j*IW +: IW] != 0 || cnt_o[j*CW +: CW] != 0) bad_tail++;
    chk(int'(num_o) == k, "R3", {tag, " num"}, int'(num_o), k);
    chk(bad_ord == 0, "R1 R2", {tag, " slot content"}, first_act, first_exp);
    chk(bad_tail == 0, "R4", {tag, " tail slots nonzero"}, bad_tail, 0);
  endtask

  task automatic wait_done(input string tag, input int start_cyc);
    int cyc;
    cyc = start_cyc;
    while (!done_o && cyc < 100) begin
      @(negedge clk);
      cyc++;
    end
    if (cyc >= 100) chk(1'b0, "R5", {tag, " watchdog"}, cyc, 10);
    else chk(cyc == 10, "R5", {tag, " latency"}, cyc, 10);
    @(negedge clk);
    chk(!done_o, "R5", {tag, " done width"}, int'(done_o), 0);
  endtask

  task automatic run_case(input string tag);
    @(negedge clk);
    counts_i = pack_hist();
    valid_i  = 1'b1;
    @(negedge clk);
    valid_i  = 1'b0;
    wait_done(tag, 1);
    check_result(tag);
  endtask

  initial begin
    #(4 * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R8: reset state
    chk(done_o == 1'b0, "R8", "done after reset", int'(done_o), 0);
    chk(num_o == 0, "R8", "num after reset", int'(num_o), 0);
    chk(idx_o == '0 && cnt_o == '0, "R8", "slots after reset", int'(|{idx_o, cnt_o}), 0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk);

    // R7: empty bank
    for (int i = 0; i < NB; i++) hist[i] = '0;
    run_case("R7 empty");
    chk(num_o == 0, "R7", "empty num", int'(num_o), 0);

    // worked example in the low bins
    for (int i = 0; i < NB; i++) hist[i] = '0;
    hist[0] = 4; hist[1] = 3; hist[3] = 2; hist[4] = 1; hist[6] = 5;
    run_case("example");
    chk(idx_o[4*IW +: IW] == 6 && cnt_o[4*CW +: CW] == 5, "R2", "example slot4",
        int'(idx_o[4*IW +: IW]), 6);

    // R3: full bank at maximum count
    for (int i = 0; i < NB; i++) hist[i] = '1;
    run_case("full max");
    chk(num_o == 256, "R3", "full count", int'(num_o), 256);

    // full bank at count one
    for (int i = 0; i < NB; i++) hist[i] = 8'd1;
    run_case("full ones");

    // single bins at both ends
    for (int i = 0; i < NB; i++) hist[i] = '0;
    hist[0] = 8'd9;
    run_case("bin0 only");
    for (int i = 0; i < NB; i++) hist[i] = '0;
    hist[NB-1] = 8'd200;
    run_case("bin255 only");
    chk(idx_o[IW-1:0] == 8'd255, "R2", "last bin to slot0", int'(idx_o[IW-1:0]), 255);

    // alternating and sparse strides
    for (int i = 0; i < NB; i++) hist[i] = (i % 2 == 1) ? CW'(i) : '0;
    run_case("odd bins");
    for (int i = 0; i < NB; i++) hist[i] = (i % 37 == 5) ? 8'd77 : '0;
    run_case("stride37");

    // random occupancy sweep
    for (int r = 0; r < 24; r++) begin
      int dens;
      dens = (r * 9) % 101;
      for (int i = 0; i < NB; i++)
        hist[i] = ($urandom_range(0, 99) < dens) ? CW'($urandom_range(1, 255)) : '0;
      run_case($sformatf("rand%0d", r));
    end

    // R9: hold after done
    begin
      logic [8:0] n0;
      logic [NB*IW-1:0] i0;
      n0 = num_o; i0 = idx_o;
      repeat (7) @(negedge clk);
      chk(num_o == n0 && idx_o == i0, "R9", "hold after done", int'(num_o), int'(n0));
    end

    // R6: second request during a run is ignored
    for (int i = 0; i < NB; i++) hist[i] = (i < 10) ? 8'd3 : '0;
    @(negedge clk);
    counts_i = pack_hist();
    valid_i = 1'b1;
    @(negedge clk);
    valid_i = 1'b0;
    @(negedge clk);
    counts_i = '1;
    valid_i = 1'b1;
    @(negedge clk);
    valid_i = 1'b0;
    wait_done("R6 busy", 3);
    check_result("R6 busy");
    chk(num_o == 10, "R6", "busy pulse ignored", int'(num_o), 10);
    begin
      int extra;
      extra = 0;
      repeat (15) begin
        @(negedge clk);
        if (done_o) extra++;
      end
      chk(extra == 0, "R6", "no second done", extra, 0);
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule